// File: doc/BRIEF.md
# Bridge Legacy I/O Window Decoder

This block sits in the downstream port of a PCI-to-PCI style bridge. For every I/O cycle the CPU starts, it decides whether the cycle should be passed on to the secondary link. It compares the 16-bit I/O address against an inclusive base/limit window with 4 KB granularity. Two legacy overrides then apply. ISA mode keeps the upper three quarters of every 1 KB block inside the window on the primary side. VGA mode claims the standard display adapter port ranges, either through 10-bit aliased matching or through exact 16-bit matching.

Three control bits are loaded through a one-cycle write strobe: ISA mode, VGA enable and VGA full decode. The window base and limit come from elsewhere as plain inputs. A request is a valid strobe with an address. One clock later the block presents a registered response with a valid, a forward decision and a flag marking a VGA-range hit.

The response stage is a two-state machine. `RSP_IDLE` means no response is being presented. `RSP_BUSY` means a response is being presented. It takes the transition *accept* (IDLE→BUSY) on a request, *chain* (BUSY→BUSY) on a back-to-back request, *drain* (BUSY→IDLE) when no request arrives, and *rest* (IDLE→IDLE) when it stays idle.

Top module: `iowin_decoder`

## Requirements
- R1: After reset, all three control bits are 0 and `rsp_valid`, `rsp_forward` and `rsp_vga_hit` are all 0.
- R2: A cycle with `cfg_we`=1 loads `cfg_wdata` into the control bits: bit 0 is ISA mode, bit 1 is VGA enable and bit 2 is VGA full decode. The new value applies to requests in later cycles. A request in the same cycle as the write uses the old value.
- R3: The window is inclusive. The effective base is `io_base` with bits [11:0] cleared, and the effective limit is `io_limit` with bits [11:0] set.
- R4: With ISA mode 0, every address inside the window is forwarded.
- R5: With ISA mode 1, an address inside the window is not forwarded when its address bits [9:8] are not both 0. It is forwarded when bits [9:8] are both 0.
- R6: An address outside the window is never forwarded unless it is a VGA hit.
- R7: With VGA enable 1 and full decode 0, an address is a VGA hit when its bits [9:0] lie in 3B0h–3BBh or 3C0h–3DFh. Bits [15:10] are ignored.
- R8: With VGA enable 1 and full decode 1, an address is a VGA hit only when all 16 bits lie in 3B0h–3BBh or 3C0h–3DFh.
- R9: With VGA enable 0, `rsp_vga_hit` stays 0 and the full decode bit has no effect on any response.
- R10: A VGA hit is forwarded regardless of the window and of ISA mode.
- R11: A request accepted at a clock edge produces `rsp_valid`=1 with its decision after that edge. When no request was accepted at the edge, `rsp_valid`, `rsp_forward` and `rsp_vga_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control-bit write strobe |
| cfg_wdata | input | 3 | Control bits: [0] ISA mode, [1] VGA enable, [2] VGA full decode |
| io_base | input | 16 | I/O window base (bits [11:0] ignored) |
| io_limit | input | 16 | I/O window limit (bits [11:0] ignored) |
| req_valid | input | 1 | I/O request strobe |
| req_addr | input | 16 | I/O request address |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_forward | output | 1 | 1 = pass the cycle to the secondary link |
| rsp_vga_hit | output | 1 | 1 = the address was claimed as a VGA port |

## Verification
Three cases are hard to reach with random addresses: an address that is both a VGA alias and inside a window with ISA mode set, a window edge at exactly the granule boundary, and a control write that lands in the same cycle as a request. The stimulus biases addresses toward the VGA port ranges with random upper bits, and it places window edges on the granule boundaries to pick their neighbours. It also issues control writes both between requests and coincident with them, so the old-versus-new control value is exercised.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

    // Control bits as stored; packed so bit0 = isa_en, bit1 = vga_en, bit2 = full16
    typedef struct packed {
        logic full16;
        logic vga_en;
        logic isa_en;
    } iowin_ctrl_t;

    localparam int CTRL_W = $bits(iowin_ctrl_t);

    typedef enum logic [0:0] {
        RSP_IDLE = 1'b0,
        RSP_BUSY = 1'b1
    } rsp_state_t;

    // Legacy display adapter port ranges (16-bit values)
    localparam logic [15:0] VGA_MONO_LO = 16'h03B0;
    localparam logic [15:0] VGA_MONO_HI = 16'h03BB;
    localparam logic [15:0] VGA_COLR_LO = 16'h03C0;
    localparam logic [15:0] VGA_COLR_HI = 16'h03DF;

endpackage

// File: rtl/iowin_ctrl_reg.sv
module iowin_ctrl_reg
    import iowin_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [CTRL_W-1:0]   wdata,
    output iowin_ctrl_t         ctrl
);

    iowin_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we) begin
            ctrl_q <= iowin_ctrl_t'(wdata);
        end
    end

    assign ctrl = ctrl_q;

    AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(we) && $past(rst_n) |-> $stable(ctrl_q)) else $error("ctrl changed without write"); // R2

endmodule

// File: rtl/iowin_range_chk.sv
module iowin_range_chk #(
    parameter int ADDR_W = 16,
    parameter int GRAN_W = 12,
    parameter int BLK_W  = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  logic              isa_en,
    output logic              in_win,
    output logic              pass
);

    localparam int ISA_HI = BLK_W - 1;
    localparam int ISA_LO = BLK_W - 2;

    logic [ADDR_W-1:0] base_eff;
    logic [ADDR_W-1:0] limit_eff;
    logic              isa_drop;

    // Align window edges to the granule
    assign base_eff  = {base[ADDR_W-1:GRAN_W],  {GRAN_W{1'b0}}};
    assign limit_eff = {limit[ADDR_W-1:GRAN_W], {GRAN_W{1'b1}}};

    assign in_win   = (addr >= base_eff) && (addr <= limit_eff);
    // Upper three quarters of each 1 KB block
    assign isa_drop = isa_en && (addr[ISA_HI:ISA_LO] != 2'b00);
    assign pass     = in_win && !isa_drop;

endmodule

// File: rtl/iowin_vga_match.sv
module iowin_vga_match
    import iowin_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              vga_en,
    input  logic              full16,
    output logic              hit
);

    logic [ADDR_W-1:0] folded;
    logic [ADDR_W-1:0] cmp_addr;
    logic              mono_hit;
    logic              colr_hit;

    // 10-bit decode ignores the alias bits above the 1 KB block
    generate
        if (ADDR_W > BLK_W) begin : g_fold
            assign folded = {{(ADDR_W-BLK_W){1'b0}}, addr[BLK_W-1:0]};
        end else begin : g_nofold
            assign folded = addr;
        end
    endgenerate

    assign cmp_addr = full16 ? addr : folded;

    assign mono_hit = (cmp_addr >= ADDR_W'(VGA_MONO_LO)) && (cmp_addr <= ADDR_W'(VGA_MONO_HI));
    assign colr_hit = (cmp_addr >= ADDR_W'(VGA_COLR_LO)) && (cmp_addr <= ADDR_W'(VGA_COLR_HI));
    assign hit      = vga_en && (mono_hit || colr_hit);

endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
    import iowin_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int GRAN_W = 12,
    parameter int BLK_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_wdata,
    input  logic [ADDR_W-1:0] io_base,
    input  logic [ADDR_W-1:0] io_limit,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_forward,
    output logic              rsp_vga_hit
);

    iowin_ctrl_t ctrl_q;
    logic        win_in;
    logic        win_pass;
    logic        vga_hit_c;
    logic        fwd_c;
    rsp_state_t  state_q;
    rsp_state_t  state_d;
    logic        fwd_q;
    logic        vga_q;

    iowin_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .ctrl  (ctrl_q)
    );

    iowin_range_chk #(
        .ADDR_W (ADDR_W),
        .GRAN_W (GRAN_W),
        .BLK_W  (BLK_W)
    ) u_range (
        .addr   (req_addr),
        .base   (io_base),
        .limit  (io_limit),
        .isa_en (ctrl_q.isa_en),
        .in_win (win_in),
        .pass   (win_pass)
    );

    iowin_vga_match #(
        .ADDR_W (ADDR_W),
        .BLK_W  (BLK_W)
    ) u_vga (
        .addr   (req_addr),
        .vga_en (ctrl_q.vga_en),
        .full16 (ctrl_q.full16),
        .hit    (vga_hit_c)
    );

    // VGA claim overrides the window and the ISA hole
    assign fwd_c = vga_hit_c || win_pass;

    // Next-state: accept / chain / drain / rest
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_IDLE: state_d = req_valid ? RSP_BUSY : RSP_IDLE;
            RSP_BUSY: state_d = req_valid ? RSP_BUSY : RSP_IDLE;
            default:  state_d = RSP_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    // Registered decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_q <= 1'b0;
            vga_q <= 1'b0;
        end else if (req_valid) begin
            fwd_q <= fwd_c;
            vga_q <= vga_hit_c;
        end else begin
            fwd_q <= 1'b0;
            vga_q <= 1'b0;
        end
    end

    assign rsp_valid   = (state_q == RSP_BUSY);
    assign rsp_forward = fwd_q;
    assign rsp_vga_hit = vga_q;

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid)) else $error("response latency"); // R11
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_forward && !rsp_vga_hit) else $error("idle outputs"); // R11
    AST_VGA_CLAIMS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vga_hit |-> rsp_forward) else $error("vga hit not forwarded"); // R10
    AST_VGA_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vga_hit |-> $past(ctrl_q.vga_en)) else $error("vga hit while disabled"); // R9
    AST_ISA_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_vga_hit && $past(ctrl_q.isa_en) && ($past(req_addr[BLK_W-1:BLK_W-2]) != 2'b00)
        |-> !rsp_forward) else $error("isa hole forwarded"); // R5
    AST_OUTSIDE_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_forward && !rsp_vga_hit |->
        ($past(req_addr[ADDR_W-1:GRAN_W]) >= $past(io_base[ADDR_W-1:GRAN_W])) &&
        ($past(req_addr[ADDR_W-1:GRAN_W]) <= $past(io_limit[ADDR_W-1:GRAN_W])))
        else $error("forward outside window"); // R6

endmodule

// File: tb/iowin_decoder_test.sv
module iowin_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_wdata = '0;
    logic [15:0] io_base = '0;
    logic [15:0] io_limit = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        rsp_valid, rsp_forward, rsp_vga_hit;

    int n_vec = 0;
    int n_bad = 0;
    bit m_isa = 0, m_ven = 0, m_v16 = 0;

    always #2 clk = ~clk;

    iowin_decoder uut (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .io_base (io_base), .io_limit (io_limit), .req_valid (req_valid),
        .req_addr (req_addr), .rsp_valid (rsp_valid), .rsp_forward (rsp_forward),
        .rsp_vga_hit (rsp_vga_hit)
    );

    function automatic bit vga_exp(input logic [15:0] a, input bit ven, input bit v16);
        logic [15:0] c;
        c = v16 ? a : {6'b0, a[9:0]};
        return ven && (((c >= 16'h03B0) && (c <= 16'h03BB)) || ((c >= 16'h03C0) && (c <= 16'h03DF)));
    endfunction

    function automatic bit fwd_exp(input logic [15:0] a, input logic [15:0] b, input logic [15:0] l,
                                   input bit isa, input bit ven, input bit v16);
        bit inw;
        inw = (a >= {b[15:12], 12'h000}) && (a <= {l[15:12], 12'hFFF});
        return vga_exp(a, ven, v16) || (inw && !(isa && (a[9:8] != 2'b00)));
    endfunction

    task automatic chk(input string rq, input logic [2:0] act, input logic [2:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {valid,fwd,vga} actual=%b expected=%b", rq, act, exp);
        end
    endtask

    task automatic wr_ctrl(input bit isa, input bit ven, input bit v16);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = {v16, ven, isa};
        @(negedge clk);
        cfg_we = 1'b0;
        m_isa = isa; m_ven = ven; m_v16 = v16;
    endtask

    task automatic req(input string rq, input logic [15:0] a);
        logic [2:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        e = {1'b1, fwd_exp(a, io_base, io_limit, m_isa, m_ven, m_v16), vga_exp(a, m_ven, m_v16)};
        @(negedge clk);
        req_valid = 1'b0;
        chk(rq, {rsp_valid, rsp_forward, rsp_vga_hit}, e);
    endtask

    // Write and request in the same cycle: the request sees the old bits
    task automatic wr_and_req(input string rq, input logic [2:0] bits, input logic [15:0] a);
        logic [2:0] e;
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = bits; req_valid = 1'b1; req_addr = a;
        e = {1'b1, fwd_exp(a, io_base, io_limit, m_isa, m_ven, m_v16), vga_exp(a, m_ven, m_v16)};
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        m_isa = bits[0]; m_ven = bits[1]; m_v16 = bits[2];
        chk(rq, {rsp_valid, rsp_forward, rsp_vga_hit}, e);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        logic [15:0] a;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset outputs", {rsp_valid, rsp_forward, rsp_vga_hit}, 3'b000);
        rst_n = 1'b1;
        io_base = 16'h1000; io_limit = 16'h1000;
        req("R1 vga off after reset", 16'h03C0);
        req("R1 isa off after reset", 16'h1300);
        // R3 window granularity
        io_base = 16'h2345; io_limit = 16'h4001;
        req("R3 base edge", 16'h2000);
        req("R3 below base", 16'h1FFF);
        req("R3 limit edge", 16'h4FFF);
        req("R3 above limit", 16'h5000);
        req("R4 isa off upper quarter", 16'h2300);
        // R2 + R5
        wr_ctrl(1, 0, 0);
        req("R5 isa keeps low quarter", 16'h2000);
        req("R5 isa drops 100h", 16'h2100);
        req("R5 isa drops 3FFh", 16'h23FF);
        req("R5 isa keeps 4FFh", 16'h24FF);
        req("R6 outside window", 16'h1000);
        // R7 aliased VGA
        wr_ctrl(0, 1, 0);
        req("R7 alias 7C0h", 16'h07C0);
        req("R7 3DFh", 16'h03DF);
        req("R7 3E0h miss", 16'h03E0);
        req("R7 3BCh miss", 16'h03BC);
        req("R7 alias FFB0h", 16'hFFB0);
        // R8 full decode
        wr_ctrl(0, 1, 1);
        req("R8 alias 7C0h rejected", 16'h07C0);
        req("R8 3B0h", 16'h03B0);
        // R10 VGA beats ISA and window
        wr_ctrl(1, 1, 0);
        req("R10 vga outside window isa", 16'h03C0);
        req("R10 vga alias in isa hole", 16'h23C0);
        // R9 full decode without enable
        wr_ctrl(0, 0, 1);
        req("R9 no vga flag", 16'h03C0);
        req("R9 in window no flag", 16'h23C0);
        // R2/R11 same-cycle write uses old bits
        wr_and_req("R2 write-coincident request", 3'b001, 16'h2100);
        req("R2 new bits applied", 16'h2100);
        // R11 idle outputs
        @(negedge clk);
        chk("R11 idle after response", {rsp_valid, rsp_forward, rsp_vga_hit}, 3'b000);
        // Random mix
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 8) == 0) begin
                logic [2:0] b;
                b = 3'($urandom);
                if (($urandom % 2) == 0) wr_ctrl(b[0], b[1], b[2]);
                else wr_and_req("R2 random coincident write", b, 16'($urandom));
            end
            if (($urandom % 16) == 0) begin
                io_base  = 16'($urandom);
                io_limit = 16'($urandom);
            end
            case ($urandom % 4)
                0: a = {6'($urandom), 10'h3B0 + 10'($urandom % 48)};
                1: a = {io_base[15:12], 12'($urandom)};
                2: a = {io_limit[15:12] + 4'($urandom % 2), 12'($urandom % 2 ? 12'h000 : 12'hFFF)};
                default: a = 16'($urandom);
            endcase
            req("R4-R10 random", a);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule